// File: doc/BRIEF.md
# Serial access-layer instruction decoder

This block is the access layer of a serial debug and programming port whose instructions are one byte long. A physical layer beneath it turns the serial line into whole received bytes and turns whole bytes back into serial readout. This block treats each received byte as an opcode. It recognises five instruction kinds:

- a store of the next byte into one half of a 16-bit pointer register,
- a direct-addressed read from a 64-entry I/O space,
- a direct-addressed write to the same I/O space,
- a direct-addressed read from a 16-entry control/status space,
- a direct-addressed write to that control/status space.

For an instruction that stores or writes, the block waits for the byte that follows and commits it. For a read, it strobes the addressed space once, captures the byte the space returns and offers it on the outgoing byte stream. It accepts no further opcode until that byte has been taken. The pointer register is exported for use by other access logic. Addresses for both spaces come from the opcode alone.

Top module: `serial_access_decoder`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to the idle state. After that edge, ptr is 0x0000, out_valid is 0, in_ready is 1 and all four strobes are 0.
- R2: Opcode 0x68 or 0x69 (bits 7:1 = 0110100) makes the next accepted byte replace ptr[7:0] (bit 0 = 0) or ptr[15:8] (bit 0 = 1). The other half keeps its value.
- R3: An opcode with bit 7 = 0 and bit 4 = 1 is an I/O read. Its address is {bit6, bit5, bit3, bit2, bit1, bit0}. It gives exactly one io_rd pulse at that address, and the byte the space returns is then offered on out_data with out_valid. The address does not depend on the value of ptr.
- R4: An opcode with bit 7 = 1 and bit 4 = 1 is an I/O write with the same address layout. The next accepted byte produces exactly one io_wr pulse, with that byte on io_wdata, in the cycle the byte is accepted.
- R5: Opcode 1000aaaa is a control/status read at address aaaa. It gives one cs_rd pulse, and the returned byte is offered on out_data.
- R6: Opcode 1100aaaa is a control/status write at address aaaa. The next accepted byte produces one cs_wr pulse carrying that byte.
- R7: An opcode matching none of the patterns above is consumed with no strobe and no change to ptr. The byte after it is decoded as a new opcode.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1, out_data stays stable and in_ready stays 0. No input byte is consumed until the readout byte is taken.
- R9: At most one of io_rd, io_wr, cs_rd and cs_wr is high in any cycle. A read strobe is followed two cycles later by out_valid.
- R10: Reset while a write is waiting for its data byte cancels that write. The next byte after reset is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Received byte from the physical layer |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block can take a received byte this cycle |
| out_data | output | 8 | Readout byte for the physical layer |
| out_valid | output | 1 | out_data holds a readout byte |
| out_ready | input | 1 | Physical layer takes the readout byte |
| io_addr | output | 6 | I/O space address |
| io_wdata | output | 8 | I/O space write data |
| io_wr | output | 1 | I/O space write strobe |
| io_rd | output | 1 | I/O space read strobe; data is due on io_rdata one cycle later |
| io_rdata | input | 8 | I/O space read data |
| cs_addr | output | 4 | Control/status space address |
| cs_wdata | output | 8 | Control/status write data |
| cs_wr | output | 1 | Control/status write strobe |
| cs_rd | output | 1 | Control/status read strobe; data is due on cs_rdata one cycle later |
| cs_rdata | input | 8 | Control/status read data |
| ptr | output | 16 | Pointer register |

## Verification
Two events can land in the same cycle: a readout byte is still pending, and the physical layer presents the next opcode. The bench provokes this by reading an I/O byte while out_ready is held low. During the stall it drives a pointer-store opcode onto the input. For several cycles it checks that in_ready stays low, that no strobe fires and that out_data does not move. It then releases out_ready and checks that the held opcode takes effect only after the readout handshake, by the value it leaves in ptr.

// File: rtl/serial_access_pkg.sv
// Shared widths, operation codes and the decoded-instruction record for the
// serial access-layer decoder. The opcode layout fixes every width here.
package serial_access_pkg;

    localparam int BYTE_W  = 8;
    localparam int IO_AW   = 6;
    localparam int CS_AW   = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PTR,
        OP_IO_RD,
        OP_IO_WR,
        OP_CS_RD,
        OP_CS_WR
    } op_e;

    // One decoded instruction. addr carries the I/O address, the
    // control/status address in its low bits, or the pointer half in bit 0.
    typedef struct packed {
        op_e              op;
        logic [IO_AW-1:0] addr;
    } instr_t;

endpackage

// File: rtl/sad_opdecode.sv
// Opcode decoder. Purely combinational: it classifies one byte and rebuilds
// the direct address scattered through it. It assumes the byte is an opcode;
// the sequencer decides whether the result is used.
module sad_opdecode
    import serial_access_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output instr_t            dec
);

    // Pattern match in priority order: the pointer store has bit 4 clear, so
    // it is tested first and cannot be taken for an I/O access.
    always_comb begin
        dec.op   = OP_NONE;
        dec.addr = '0;
        if (opcode[7:1] == 7'b0110100) begin
            dec.op   = OP_PTR;
            dec.addr = {{(IO_AW-1){1'b0}}, opcode[0]};
        end else if (opcode[4]) begin
            dec.op   = opcode[7] ? OP_IO_WR : OP_IO_RD;
            dec.addr = {opcode[6:5], opcode[3:0]};
        end else if (opcode[7:4] == 4'b1000) begin
            dec.op   = OP_CS_RD;
            dec.addr = {2'b00, opcode[3:0]};
        end else if (opcode[7:4] == 4'b1100) begin
            dec.op   = OP_CS_WR;
            dec.addr = {2'b00, opcode[3:0]};
        end
    end

endmodule

// File: rtl/sad_pointer.sv
// Pointer register built from byte-wide lanes. One lane at a time is
// replaced when wr_en is high; sel picks the lane. It assumes at most two
// lanes, because the opcode carries a single select bit.
module sad_pointer #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      sel,
    input  logic [BYTE_W-1:0]         wdata,
    output logic [N_BYTES*BYTE_W-1:0] ptr
);

    localparam int PTR_W = N_BYTES * BYTE_W;

    logic [PTR_W-1:0] ptr_q;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        // Lane g: cleared by reset, replaced when selected and written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && (sel == 1'(g)))
                ptr_q[g*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    assign ptr = ptr_q;

    // R2: without a write the pointer holds its value.
    a_r2_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr));

endmodule

// File: rtl/sad_sequencer.sv
// Instruction sequencer. In idle it takes an opcode (already decoded by
// sad_opdecode). A store or write waits for one data byte. A read strobes
// its space once, captures the byte the space returns one cycle later, and
// holds it on the output stream until it is taken. It assumes both spaces
// answer a read strobe with data on the following cycle.
module sad_sequencer
    import serial_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  instr_t            dec,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IO_AW-1:0]  io_addr,
    output logic              io_wr,
    output logic              io_rd,
    input  logic [BYTE_W-1:0] io_rdata,
    output logic [CS_AW-1:0]  cs_addr,
    output logic              cs_wr,
    output logic              cs_rd,
    input  logic [BYTE_W-1:0] cs_rdata,
    output logic              ptr_we,
    output logic              ptr_sel
);

    typedef enum logic [2:0] {
        S_IDLE,
        S_AWAIT,
        S_RD_ISSUE,
        S_RD_LATCH,
        S_RD_PUSH
    } state_e;

    state_e            state_q, state_d;
    instr_t            instr_q;
    logic [BYTE_W-1:0] out_q;
    logic              accept;
    logic              data_fire;

    assign in_ready  = (state_q == S_IDLE) || (state_q == S_AWAIT);
    assign accept    = in_valid && in_ready;
    assign data_fire = accept && (state_q == S_AWAIT);

    // Strobes and addresses come from the held instruction only.
    assign io_addr   = instr_q.addr;
    assign cs_addr   = instr_q.addr[CS_AW-1:0];
    assign ptr_sel   = instr_q.addr[0];
    assign io_wr     = data_fire && (instr_q.op == OP_IO_WR);
    assign cs_wr     = data_fire && (instr_q.op == OP_CS_WR);
    assign ptr_we    = data_fire && (instr_q.op == OP_PTR);
    assign io_rd     = (state_q == S_RD_ISSUE) && (instr_q.op == OP_IO_RD);
    assign cs_rd     = (state_q == S_RD_ISSUE) && (instr_q.op == OP_CS_RD);
    assign out_valid = (state_q == S_RD_PUSH);
    assign out_data  = out_q;

    // Next-state selection for the instruction sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    unique case (dec.op)
                        OP_PTR, OP_IO_WR, OP_CS_WR: state_d = S_AWAIT;
                        OP_IO_RD, OP_CS_RD:         state_d = S_RD_ISSUE;
                        default:                    state_d = S_IDLE;
                    endcase
                end
            end
            S_AWAIT:    if (accept) state_d = S_IDLE;
            S_RD_ISSUE: state_d = S_RD_LATCH;
            S_RD_LATCH: state_d = S_RD_PUSH;
            S_RD_PUSH:  if (out_ready) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register; reset drops any pending operation.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Holds the decoded opcode from acceptance until the instruction ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            instr_q <= '{op: OP_NONE, addr: '0};
        else if (accept && (state_q == S_IDLE))
            instr_q <= dec;
    end

    // Captures the read byte in the cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (state_q == S_RD_LATCH)
            out_q <= (instr_q.op == OP_IO_RD) ? io_rdata : cs_rdata;
    end

    // R9: the four strobes never overlap.
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr, cs_rd, cs_wr}));

    // R9: a read strobe leads to a readout byte two cycles later (R3, R5).
    a_r9_read_to_push: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || cs_rd) |=> ##1 out_valid);

    // R8: a stalled readout byte stays offered and unchanged.
    a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: no input byte is consumed while a readout byte is pending.
    a_r8_no_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R7: an unmatched opcode leaves the sequencer idle.
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (state_q == S_IDLE) && (dec.op == OP_NONE))
            |=> (in_ready && !io_wr && !cs_wr && !ptr_we));

endmodule

// File: rtl/serial_access_decoder.sv
// Top of the serial access-layer decoder. It wires the opcode decoder, the
// sequencer and the pointer register together. It assumes a physical layer
// that delivers and accepts whole bytes over valid/ready streams, and
// address spaces that return read data one cycle after a read strobe.
module serial_access_decoder
    import serial_access_pkg::*;
#(
    parameter int PTR_BYTES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BYTE_W-1:0]             in_data,
    input  logic                          in_valid,
    output logic                          in_ready,
    output logic [BYTE_W-1:0]             out_data,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [IO_AW-1:0]              io_addr,
    output logic [BYTE_W-1:0]             io_wdata,
    output logic                          io_wr,
    output logic                          io_rd,
    input  logic [BYTE_W-1:0]             io_rdata,
    output logic [CS_AW-1:0]              cs_addr,
    output logic [BYTE_W-1:0]             cs_wdata,
    output logic                          cs_wr,
    output logic                          cs_rd,
    input  logic [BYTE_W-1:0]             cs_rdata,
    output logic [PTR_BYTES*BYTE_W-1:0]   ptr
);

    instr_t dec;
    logic   ptr_we;
    logic   ptr_sel;

    assign io_wdata = in_data;
    assign cs_wdata = in_data;

    sad_opdecode u_dec (
        .opcode (in_data),
        .dec    (dec)
    );

    sad_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .dec       (dec),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_rdata  (io_rdata),
        .cs_addr   (cs_addr),
        .cs_wr     (cs_wr),
        .cs_rd     (cs_rd),
        .cs_rdata  (cs_rdata),
        .ptr_we    (ptr_we),
        .ptr_sel   (ptr_sel)
    );

    sad_pointer #(
        .BYTE_W  (BYTE_W),
        .N_BYTES (PTR_BYTES)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ptr_we),
        .sel   (ptr_sel),
        .wdata (in_data),
        .ptr   (ptr)
    );

    // R1: a reset edge leaves the block idle with a cleared pointer.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (ptr == '0 && !out_valid && in_ready
                    && !io_wr && !io_rd && !cs_wr && !cs_rd));

    // R4 / R6: a write strobe only fires when a byte is being taken.
    a_r4_write_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || cs_wr) |-> (in_valid && in_ready));

endmodule

// File: tb/sim_serial_access_decoder.sv
`timescale 1ns/1ps
module sim_serial_access_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [5:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        io_wr, io_rd;
    logic [7:0]  io_rdata = '0;
    logic [3:0]  cs_addr;
    logic [7:0]  cs_wdata;
    logic        cs_wr, cs_rd;
    logic [7:0]  cs_rdata = '0;
    logic [15:0] ptr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_io_wr = 0, n_io_rd = 0, n_cs_wr = 0, n_cs_rd = 0;
    logic [5:0] last_io_a;
    logic [7:0] last_io_d;
    logic [3:0] last_cs_a;
    logic [7:0] last_cs_d;
    logic [7:0] io_mem [64];
    logic [7:0] cs_mem [16];

    always #2.5 clk = ~clk;

    serial_access_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(io_rdata),
        .cs_addr(cs_addr), .cs_wdata(cs_wdata), .cs_wr(cs_wr), .cs_rd(cs_rd),
        .cs_rdata(cs_rdata),
        .ptr(ptr)
    );

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Address-space models and strobe monitor.
    initial begin
        for (int i = 0; i < 64; i++) io_mem[i] = 8'(i ^ 8'h55);
        for (int i = 0; i < 16; i++) cs_mem[i] = 8'(i ^ 8'hA0);
    end

    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (io_wr) begin io_mem[io_addr] <= io_wdata; n_io_wr++;
                             last_io_a = io_addr; last_io_d = io_wdata; end
            if (cs_wr) begin cs_mem[cs_addr] <= cs_wdata; n_cs_wr++;
                             last_cs_a = cs_addr; last_cs_d = cs_wdata; end
            if (io_rd) begin io_rdata <= io_mem[io_addr]; n_io_rd++; end
            if (cs_rd) begin cs_rdata <= cs_mem[cs_addr]; n_cs_rd++; end
            if (32'(io_wr) + 32'(io_rd) + 32'(cs_wr) + 32'(cs_rd) > 1) begin
                checks++; errors++;
                $display("FAIL R9: strobes %b expected at most one set",
                         {io_rd, io_wr, cs_rd, cs_wr});
            end
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            finish_sim();
        end
    end

    // Presents one byte from a falling edge until it is taken.
    task automatic send_byte(input logic [7:0] b);
        bit done = 0;
        int n = 0;
        in_data  = b;
        in_valid = 1'b1;
        while (!done) begin
            if (in_ready) begin
                @(posedge clk);
                done = 1;
            end else if (n > 50) begin
                check(0, "send timeout", 16'(n), 16'd50);
                done = 1;
            end
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
    endtask

    // Takes one readout byte; returns it in b.
    task automatic recv_byte(output logic [7:0] b);
        int n = 0;
        out_ready = 1'b1;
        while (!out_valid && n < 50) begin @(negedge clk); n++; end
        b = out_data;
        if (!out_valid) check(0, "readout timeout", 16'(n), 16'd50);
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Vector table: {kind, addr, data}. kind 0 I/O write, 1 I/O read,
    // 2 control write, 3 control read; for reads data is the expected byte.
    localparam logic [15:0] VEC [12] = '{
        {2'd0, 6'h2A, 8'h5C}, {2'd0, 6'h05, 8'hA3}, {2'd2, 6'h03, 8'h7E},
        {2'd0, 6'h3F, 8'hFF}, {2'd1, 6'h2A, 8'h5C}, {2'd1, 6'h05, 8'hA3},
        {2'd3, 6'h03, 8'h7E}, {2'd1, 6'h3F, 8'hFF}, {2'd2, 6'h0F, 8'h11},
        {2'd3, 6'h0F, 8'h11}, {2'd0, 6'h00, 8'h42}, {2'd1, 6'h00, 8'h42}
    };

    initial begin
        logic [7:0] rb;
        logic [7:0] held;
        int         base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset.
        check(ptr == 16'h0000, "R1 ptr", ptr, 16'h0000);
        check(in_ready == 1'b1, "R1 in_ready", 16'(in_ready), 16'd1);
        check(out_valid == 1'b0, "R1 out_valid", 16'(out_valid), 16'd0);
        check({io_wr, io_rd, cs_wr, cs_rd} == 4'b0, "R1 strobes",
              16'({io_wr, io_rd, cs_wr, cs_rd}), 16'd0);

        // R2: both pointer halves.
        send_byte(8'h68); send_byte(8'h34);
        check(ptr == 16'h0034, "R2 low byte", ptr, 16'h0034);
        send_byte(8'h69); send_byte(8'h12);
        check(ptr == 16'h1234, "R2 high byte", ptr, 16'h1234);

        // R3-R6: table walk, with ptr nonzero to show direct addressing.
        foreach (VEC[i]) begin
            logic [1:0] k = VEC[i][15:14];
            logic [5:0] a = VEC[i][13:8];
            logic [7:0] d = VEC[i][7:0];
            case (k)
                2'd0: begin
                    base = n_io_wr;
                    send_byte({1'b1, a[5:4], 1'b1, a[3:0]});
                    send_byte(d);
                    check(n_io_wr == base + 1, "R4 io_wr count", 16'(n_io_wr), 16'(base + 1));
                    check(last_io_a == a && last_io_d == d, "R4 io_wr addr/data",
                          {2'b0, last_io_a, last_io_d}, {2'b0, a, d});
                end
                2'd1: begin
                    base = n_io_rd;
                    send_byte({1'b0, a[5:4], 1'b1, a[3:0]});
                    recv_byte(rb);
                    check(rb == d, "R3 io readout", 16'(rb), 16'(d));
                    check(n_io_rd == base + 1, "R3 io_rd count", 16'(n_io_rd), 16'(base + 1));
                end
                2'd2: begin
                    base = n_cs_wr;
                    send_byte({4'b1100, a[3:0]});
                    send_byte(d);
                    check(n_cs_wr == base + 1 && last_cs_a == a[3:0] && last_cs_d == d,
                          "R6 cs write", {4'(n_cs_wr - base), last_cs_a, last_cs_d},
                          {4'd1, a[3:0], d});
                end
                default: begin
                    base = n_cs_rd;
                    send_byte({4'b1000, a[3:0]});
                    recv_byte(rb);
                    check(rb == d && n_cs_rd == base + 1, "R5 cs readout",
                          {4'(n_cs_rd - base), 4'h0, rb}, {4'd1, 4'h0, d});
                end
            endcase
        end
        check(ptr == 16'h1234, "R3 ptr untouched by accesses", ptr, 16'h1234);

        // R7: unmatched opcodes.
        base = n_io_wr + n_io_rd + n_cs_wr + n_cs_rd;
        send_byte(8'h00); send_byte(8'hA5); send_byte(8'hE0);
        send_byte(8'h60); send_byte(8'h6A);
        check(n_io_wr + n_io_rd + n_cs_wr + n_cs_rd == base, "R7 no strobe",
              16'(n_io_wr + n_io_rd + n_cs_wr + n_cs_rd), 16'(base));
        check(ptr == 16'h1234 && in_ready, "R7 ptr and idle", ptr, 16'h1234);
        send_byte(8'h68); send_byte(8'h77);
        check(ptr == 16'h1277, "R7 next byte is opcode", ptr, 16'h1277);

        // R8: readout stalled while the next opcode waits.
        send_byte(8'h1A);                 // I/O read, address 0x0A
        repeat (4) @(negedge clk);
        held = out_data;
        check(out_valid == 1'b1, "R8 out_valid held", 16'(out_valid), 16'd1);
        check(held == io_mem[6'h0A], "R8 readout value", 16'(held), 16'(io_mem[6'h0A]));
        base = n_io_wr + n_io_rd + n_cs_wr + n_cs_rd;
        in_data = 8'h69; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R8 in_ready low", 16'(in_ready), 16'd0);
        check(out_data == held && out_valid, "R8 out_data stable", 16'(out_data), 16'(held));
        check(n_io_wr + n_io_rd + n_cs_wr + n_cs_rd == base, "R8 no strobe in stall",
              16'(n_io_wr + n_io_rd + n_cs_wr + n_cs_rd), 16'(base));
        check(ptr == 16'h1277, "R8 held opcode not taken", ptr, 16'h1277);
        recv_byte(rb);
        send_byte(8'h69); send_byte(8'hC3);
        check(ptr == 16'hC377, "R8 opcode taken after readout", ptr, 16'hC377);

        // R10: reset while a control write waits for data.
        base = n_cs_wr;
        send_byte(8'hC5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(ptr == 16'h0000 && in_ready, "R10 reset clears", ptr, 16'h0000);
        send_byte(8'h69); send_byte(8'hAB);
        check(n_cs_wr == base, "R10 write cancelled", 16'(n_cs_wr), 16'(base));
        check(ptr == 16'hAB00, "R10 byte decoded as opcode", ptr, 16'hAB00);

        repeat (2) @(negedge clk);
        finish_sim();
    end

endmodule